// File: doc/BRIEF.md
# Duration-Qualified Pattern-Edge Trigger

This block watches a stream of sampled binary channels and raises a trigger when a masked pattern meets a duration rule. Each accepted sample is first compared with a value word. Only the channels selected by a care mask take part in that compare. The block then counts how many accepted samples in a row have matched. The count saturates at its top value and returns to zero on a sample that does not match.

Two qualification modes exist. In long mode the pattern must have held for more than a programmed number of samples. A selected rising or falling transition on the edge-masked channels must then arrive to fire. In short mode the block fires when a run of matching samples ends before the programmed number of samples has been reached.

The block watches only while armed. Arming comes from a run pulse, or from an arm line driven by a second analyzer when that path is enabled. After a trigger the block either goes idle until it is armed again, or stays armed and starts a fresh search. Samples arrive over a valid/ready interface. The block never applies back-pressure, so ready is held high and every cycle with valid high is one sample. Cycles with valid low do not advance sample time. Masks, mode and duration are expected to stay constant while the block is armed.

Top module: `pdt_trigger`

## Requirements
- R1: After reset, trig_o and armed_o are low and smp_ready_o is high.
- R2: A high run_i, or a high ext_arm_i while ext_arm_en_i is high, sets armed_o in the next cycle. A high ext_arm_i while ext_arm_en_i is low has no effect. Samples accepted while armed_o is low never cause a trigger.
- R3: A sample matches when every channel with a set care_i bit equals the same bit of value_i. Channels with a clear care_i bit are ignored.
- R4: The run count is the number of consecutive matching accepted samples since arming or since the last trigger. It saturates at 2^CNT_W-1 and is cleared by a non-matching sample. Cycles with smp_valid_i low leave it unchanged.
- R5: In long mode (mode_i=1), an accepted sample fires when the run count before it is greater than dur_i and that sample carries a selected edge.
- R6: Channel i shows a selected edge when rise_i[i] is set and it goes from 0 to 1 between consecutive accepted samples, or when fall_i[i] is set and it goes from 1 to 0. Setting both bits selects either direction.
- R7: In long mode, a non-matching sample without a selected edge drops the run, and the pattern must again hold for more than dur_i samples.
- R8: In short mode (mode_i=0), a non-matching accepted sample fires when the run count before it lies between 1 and dur_i-1.
- R9: trig_o is high for exactly one cycle, the cycle after the clock edge that accepts the firing sample.
- R10: If repeat_i is low when a sample fires, armed_o falls in the same cycle that trig_o rises. It stays low until the block is armed again.
- R11: If repeat_i is high when a sample fires, armed_o stays high and the run count restarts from zero.
- R12: smp_ready_o is high in every cycle after reset, so no sample is ever held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Local arm request |
| ext_arm_i | input | 1 | Arm request from a second analyzer |
| ext_arm_en_i | input | 1 | Enables the ext_arm_i path |
| repeat_i | input | 1 | Stay armed after a trigger |
| mode_i | input | 1 | 1 = longer-than with edge, 0 = shorter-than |
| dur_i | input | CNT_W | Duration threshold in samples |
| care_i | input | CH_W | Channels taking part in the pattern compare |
| value_i | input | CH_W | Pattern value |
| rise_i | input | CH_W | Channels qualifying on a rising edge |
| fall_i | input | CH_W | Channels qualifying on a falling edge |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_data_i | input | CH_W | Sampled channel levels |
| smp_ready_o | output | 1 | Sample accepted (always high) |
| armed_o | output | 1 | Block is watching for the trigger |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The assertions assume that dur_i, the masks and mode_i do not change while armed_o is high. They also assume that reset is applied before any sample. The bench keeps to this by changing configuration only while the block is idle or held in reset. It then arms the block and streams samples, with idle gaps, changes on ignored channels, drops in the pattern and runs long enough to saturate the counter. A behavioural model is updated on every clock and compared with trig_o and armed_o. Hand-computed trigger counts are checked at the end of each scenario.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic {
    DWELL_SHORT = 1'b0,
    DWELL_LONG  = 1'b1
  } dwell_mode_e;
endpackage

// File: rtl/pdt_chan_cmp.sv
module pdt_chan_cmp #(
  parameter int CH_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [CH_W-1:0] data,
  input  logic [CH_W-1:0] care,
  input  logic [CH_W-1:0] value,
  input  logic [CH_W-1:0] rise,
  input  logic [CH_W-1:0] fall,
  output logic            hit,
  output logic            edge_hit
);
  logic [CH_W-1:0] prev_q;
  logic [CH_W-1:0] mism;
  logic [CH_W-1:0] edg;

  // per-channel compare and transition detect
  for (genvar i = 0; i < CH_W; i++) begin : g_chan
    assign mism[i] = care[i] & (data[i] ^ value[i]);
    assign edg[i]  = (rise[i] & ~prev_q[i] & data[i]) |
                     (fall[i] &  prev_q[i] & ~data[i]);
  end

  assign hit      = ~|mism;
  assign edge_hit = |edg;

  // last accepted sample, for transition detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev_q <= '0;
    else if (adv) prev_q <= data;
  end
endmodule

// File: rtl/pdt_dwell_cnt.sv
module pdt_dwell_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (clr)                      cnt_q <= '0;
    else if (inc && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R4
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/pdt_arm_ctrl.sv
module pdt_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic fire,
  input  logic repeat_en,
  output logic armed,
  output logic trig
);
  logic armed_q;
  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= fire;
      if (!armed_q) armed_q <= arm_req;
      else if (fire && !repeat_en) armed_q <= 1'b0;
    end
  end

  assign armed = armed_q;
  assign trig  = trig_q;

  // R10
  single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !repeat_en) |=> (!armed_q && trig_q));

  // R11
  rearm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && repeat_en) |=> (armed_q && trig_q));

  // R2
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !arm_req) |=> !armed_q);
endmodule

// File: rtl/pdt_trigger.sv
module pdt_trigger #(
  parameter int CH_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             ext_arm_i,
  input  logic             ext_arm_en_i,
  input  logic             repeat_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] dur_i,
  input  logic [CH_W-1:0]  care_i,
  input  logic [CH_W-1:0]  value_i,
  input  logic [CH_W-1:0]  rise_i,
  input  logic [CH_W-1:0]  fall_i,
  input  logic             smp_valid_i,
  input  logic [CH_W-1:0]  smp_data_i,
  output logic             smp_ready_o,
  output logic             armed_o,
  output logic             trig_o
);
  import pdt_pkg::*;

  dwell_mode_e      mode;
  logic             adv;
  logic             hit;
  logic             edge_hit;
  logic [CNT_W-1:0] run_cnt;
  logic             long_ok;
  logic             short_ok;
  logic             fire;
  logic             cnt_clr;
  logic             cnt_inc;
  logic             arm_req;

  assign mode        = dwell_mode_e'(mode_i);
  assign smp_ready_o = 1'b1;
  assign adv         = armed_o & smp_valid_i;
  assign arm_req     = run_i | (ext_arm_i & ext_arm_en_i);

  pdt_chan_cmp #(.CH_W(CH_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .data     (smp_data_i),
    .care     (care_i),
    .value    (value_i),
    .rise     (rise_i),
    .fall     (fall_i),
    .hit      (hit),
    .edge_hit (edge_hit)
  );

  // qualification against the run length before this sample
  assign long_ok  = run_cnt > dur_i;
  assign short_ok = (run_cnt != '0) && (run_cnt < dur_i);

  always_comb begin
    fire = 1'b0;
    if (adv) begin
      if (mode == DWELL_LONG) fire = long_ok & edge_hit;
      else                    fire = ~hit & short_ok;
    end
  end

  assign cnt_clr = ~armed_o | fire | (adv & ~hit);
  assign cnt_inc = adv & hit;

  pdt_dwell_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (run_cnt)
  );

  pdt_arm_ctrl u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_req   (arm_req),
    .fire      (fire),
    .repeat_en (repeat_i),
    .armed     (armed_o),
    .trig      (trig_o)
  );

  // R2
  trig_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(armed_o));

  // R9
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  // R5
  long_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && $past(mode_i)) |-> ($past(edge_hit) && $past(run_cnt) > $past(dur_i)));

  // R8
  short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && !$past(mode_i)) |-> (!$past(hit) && $past(run_cnt) != '0));
endmodule

// File: tb/test_pdt_trigger.sv
module test_pdt_trigger;
  localparam int CLK_PERIOD = 10;
  localparam int CH_W  = 8;
  localparam int CNT_W = 4;
  localparam int MAXC  = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 0, ext_arm_i = 0, ext_arm_en_i = 0, repeat_i = 0, mode_i = 0;
  logic [CNT_W-1:0] dur_i = '0;
  logic [CH_W-1:0] care_i = '0, value_i = '0, rise_i = '0, fall_i = '0, smp_data_i = '0;
  logic smp_valid_i = 0;
  logic smp_ready_o, armed_o, trig_o;

  int n_chk = 0, n_fail = 0, trig_seen = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdt_trigger #(.CH_W(CH_W), .CNT_W(CNT_W)) i_pdt_trigger (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .ext_arm_i(ext_arm_i),
    .ext_arm_en_i(ext_arm_en_i), .repeat_i(repeat_i), .mode_i(mode_i),
    .dur_i(dur_i), .care_i(care_i), .value_i(value_i), .rise_i(rise_i),
    .fall_i(fall_i), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .smp_ready_o(smp_ready_o), .armed_o(armed_o), .trig_o(trig_o)
  );

  // behavioural reference model
  int m_cnt = 0;
  bit m_armed = 0, m_trig = 0;
  logic [CH_W-1:0] m_prev = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_armed = 0; m_trig = 0; m_prev = '0;
    end else begin
      m_trig = 0;
      if (!m_armed) begin
        m_cnt = 0;
        if (run_i || (ext_arm_i && ext_arm_en_i)) m_armed = 1;
      end else if (smp_valid_i) begin
        bit match, m_edge, fire;
        match  = ((smp_data_i ^ value_i) & care_i) == '0;
        m_edge = |((rise_i & ~m_prev & smp_data_i) | (fall_i & m_prev & ~smp_data_i));
        if (mode_i) fire = (m_cnt > int'(dur_i)) && m_edge;
        else        fire = !match && m_cnt >= 1 && m_cnt < int'(dur_i);
        if (fire) begin
          m_trig = 1; m_cnt = 0;
          if (!repeat_i) m_armed = 0;
        end else if (match) begin
          m_cnt = (m_cnt == MAXC) ? MAXC : m_cnt + 1;
        end else begin
          m_cnt = 0;
        end
        m_prev = smp_data_i;
      end
    end
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (trig_o) trig_seen++;
      check("R9", {cur_req, " trig_o vs model"}, int'(trig_o), int'(m_trig));
      check("R2", {cur_req, " armed_o vs model"}, int'(armed_o), int'(m_armed));
    end
  end

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; run_i = 0; ext_arm_i = 0; ext_arm_en_i = 0; smp_valid_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    trig_seen = 0;
  endtask

  task automatic arm();
    @(negedge clk); run_i = 1; smp_valid_i = 0;
    @(negedge clk); run_i = 0;
  endtask

  task automatic beat(input logic [CH_W-1:0] d);
    @(negedge clk); smp_valid_i = 1; smp_data_i = d;
  endtask

  task automatic beats(input logic [CH_W-1:0] d, input int n);
    for (int k = 0; k < n; k++) beat(d);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); smp_valid_i = 0;
    end
  endtask

  task automatic expect_trigs(input string req, input int exp);
    idle(3);
    check(req, "trigger count", trig_seen, exp);
    trig_seen = 0;
  endtask

  initial begin
    care_i = 8'h0F; value_i = 8'h05; rise_i = 8'h80; fall_i = 8'h00;
    do_reset();
    // R1 reset state, R12 ready
    check("R1", "trig_o after reset", int'(trig_o), 0);
    check("R1", "armed_o after reset", int'(armed_o), 0);
    check("R12", "smp_ready_o", int'(smp_ready_o), 1);

    // R2: ext arm gated, unarmed samples ignored
    cur_req = "R2";
    mode_i = 0; dur_i = 4;
    @(negedge clk); ext_arm_i = 1;
    @(negedge clk); ext_arm_i = 0;
    idle(1);
    check("R2", "armed_o after gated ext arm", int'(armed_o), 0);
    beats(8'h05, 2); beat(8'h00);
    expect_trigs("R2", 0);
    @(negedge clk); ext_arm_en_i = 1; ext_arm_i = 1;
    @(negedge clk); ext_arm_i = 0; ext_arm_en_i = 0;
    check("R2", "armed_o after enabled ext arm", int'(armed_o), 1);

    // R5 R6 R9 R10: long mode basic
    cur_req = "R5";
    do_reset(); mode_i = 1; dur_i = 3;
    arm(); beats(8'h05, 5); beat(8'h85);
    expect_trigs("R5", 1);
    check("R10", "armed_o after single shot", int'(armed_o), 0);
    check("R12", "smp_ready_o while running", int'(smp_ready_o), 1);

    // R5: run equal to threshold is not enough
    do_reset(); arm(); beats(8'h05, 3); beat(8'h85);
    expect_trigs("R5", 0);

    // R4: gaps do not break the run
    cur_req = "R4";
    do_reset(); arm(); beats(8'h05, 2); idle(5); beats(8'h05, 2); beat(8'h85);
    expect_trigs("R4", 1);

    // R7: drop restarts qualification
    cur_req = "R7";
    do_reset(); dur_i = 2; arm();
    beats(8'h05, 4); beat(8'h00); beat(8'h05); beat(8'h85);
    expect_trigs("R7", 0);

    // R6: rise mask does not take a fall; fall mask does
    cur_req = "R6";
    do_reset(); arm(); beats(8'h85, 4); beat(8'h05);
    expect_trigs("R6", 0);
    do_reset(); fall_i = 8'h80; rise_i = 8'h00; arm(); beats(8'h85, 4); beat(8'h05);
    expect_trigs("R6", 1);
    do_reset(); fall_i = 8'h80; rise_i = 8'h80; arm(); beats(8'h05, 4); beat(8'h85);
    expect_trigs("R6", 1);
    rise_i = 8'h80; fall_i = 8'h00;

    // R3 R8: short mode with ignored channels toggling
    cur_req = "R3";
    do_reset(); mode_i = 0; dur_i = 4; arm();
    beat(8'h35); beat(8'h65); beat(8'h04);
    expect_trigs("R3", 1);
    cur_req = "R8";
    do_reset(); arm(); beats(8'h05, 4); beat(8'h00); beat(8'h00);
    expect_trigs("R8", 0);

    // R11: repeat stays armed and restarts count
    cur_req = "R11";
    do_reset(); repeat_i = 1; arm();
    beats(8'h05, 2); beat(8'h00); beats(8'h05, 2); beat(8'h00);
    expect_trigs("R11", 2);
    check("R11", "armed_o after repeat", int'(armed_o), 1);
    repeat_i = 0;

    // R4: saturation
    cur_req = "R4";
    do_reset(); mode_i = 1; dur_i = 15; arm(); beats(8'h05, 20); beat(8'h85);
    expect_trigs("R4", 0);
    do_reset(); mode_i = 0; arm(); beats(8'h05, 20); beat(8'h00);
    expect_trigs("R4", 0);
    do_reset(); arm(); beats(8'h05, 14); beat(8'h00);
    expect_trigs("R8", 1);

    finish_up();
  end
endmodule